// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operand Extension

This block is the integer execute stage of a small load/store processor. It takes two 32-bit register operands, a 16-bit immediate, a 5-bit shift amount and a 4-bit operation code. From these it computes a 32-bit result and a flag that is high when the result is zero. The supported operations are addition, subtraction, bitwise AND, OR and NOR, set-less-than in a signed and an unsigned form, logical left and right shifts by the shift amount, and placing a constant in the upper half of a word.

The immediate passes through an extension unit. The operation code selects how the unit widens the constant: it copies the sign bit, it pads with zeros, or it moves the constant into the upper half. The immediate forms of add, AND, OR and both compares use the extended constant in place of the second register operand. No subtract-immediate exists, because adding a negative immediate does the same job. The execute logic is purely combinational. A thin wrapper registers the result and the flag, so both appear one clock after the inputs.

Top module: `rx_int_alu`

## Requirements
- R1: Code 0 (add) gives (A+B) mod 2^32, and code 1 (subtract) gives (A-B) mod 2^32. Neither operation has an overflow trap.
- R2: Code 10 (add immediate) gives A plus the 16-bit immediate after sign extension (bit 15 copied into bits 31:16), mod 2^32. An immediate of 0xFFFF therefore subtracts one.
- R3: Code 11 (AND immediate) and code 12 (OR immediate) combine A with the immediate after zero extension (bits 31:16 zero).
- R4: Codes 2, 3 and 4 give the bitwise AND, OR and NOR of A and B. NOR with B = 0 yields the inverse of A.
- R5: Code 5 gives 1 if A < B as two's-complement values and 0 otherwise. Code 13 does the same against the sign-extended immediate.
- R6: Code 6 gives 1 if A < B as unsigned values and 0 otherwise. Code 14 does the same against the sign-extended immediate taken as unsigned. With A = 0xFFFFFFFF and B = 1, code 5 gives 1 and code 6 gives 0.
- R7: Code 7 shifts A left and code 8 shifts A right by the 5-bit shift amount, filling with zeros. For example, 9 shifted left by 4 gives 144.
- R8: Code 9 places the immediate in bits 31:16 and clears bits 15:0. A and B have no effect on the result.
- R9: The zero flag is high exactly when the registered result is all zeros.
- R10: The result and the flag register on each rising clock edge, one cycle after the inputs. Reset (rst_n low) clears the result to 0 and sets the flag. Code 15 gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm_in | input | 16 | Immediate constant |
| shamt_in | input | 5 | Shift amount |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered zero flag |

## Verification
Random operands almost never reach the cases that matter most: a signed compare where the operand signs differ and the raw difference misleads, an immediate with bit 15 set feeding each extension mode, and shift amounts at 0 and 31. The stimulus therefore starts with directed vectors that place operands on the sign boundaries 0x7FFFFFFF and 0x80000000, use immediates 0x8000 and 0xFFFF, and produce results that wrap exactly to zero, so that the flag rises. A long random run follows, covering every code including the unused one. A behavioural integer model checks every cycle.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;
  localparam int XLEN    = 32;
  localparam int IMM_W   = 16;
  localparam int SHAMT_W = 5;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_NOR   = 4'd4,
    OP_SLT   = 4'd5,
    OP_SLTU  = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_LUI   = 4'd9,
    OP_ADDI  = 4'd10,
    OP_ANDI  = 4'd11,
    OP_ORI   = 4'd12,
    OP_SLTI  = 4'd13,
    OP_SLTIU = 4'd14,
    OP_RSVD  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_mode_e;
endpackage

// File: rtl/rx_imm_ext.sv
module rx_imm_ext
  import rx_alu_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_LEN = IMM_W
) (
  input  logic [IMM_LEN-1:0] imm,
  input  alu_op_e            op,
  output logic [DATA_W-1:0]  ext_val,
  output logic               imm_sel
);
  localparam int PAD = DATA_W - IMM_LEN;

  ext_mode_e mode;

  function automatic logic [DATA_W-1:0] f_sign(input logic [IMM_LEN-1:0] v);
    return {{PAD{v[IMM_LEN-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zero(input logic [IMM_LEN-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_upper(input logic [IMM_LEN-1:0] v);
    return f_zero(v) << PAD;
  endfunction

  always_comb begin
    mode    = EXT_SIGN;
    imm_sel = 1'b0;
    case (op)
      OP_ADDI, OP_SLTI, OP_SLTIU: begin mode = EXT_SIGN;  imm_sel = 1'b1; end
      OP_ANDI, OP_ORI:            begin mode = EXT_ZERO;  imm_sel = 1'b1; end
      OP_LUI:                     begin mode = EXT_UPPER; imm_sel = 1'b1; end
      default:                    begin mode = EXT_SIGN;  imm_sel = 1'b0; end
    endcase
  end

  always_comb begin
    case (mode)
      EXT_ZERO:  ext_val = f_zero(imm);
      EXT_UPPER: ext_val = f_upper(imm);
      default:   ext_val = f_sign(imm);
    endcase
  end
endmodule

// File: rtl/rx_cmp_unit.sv
module rx_cmp_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  logic [DATA_W:0] diff_ext;
  logic            sign_differs;

  function automatic logic [DATA_W:0] f_wide_sub(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  assign diff_ext     = f_wide_sub(a, b);
  assign sign_differs = a[DATA_W-1] ^ b[DATA_W-1];
  assign lt_unsigned  = diff_ext[DATA_W];
  assign lt_signed    = sign_differs ? a[DATA_W-1] : diff_ext[DATA_W-1];
endmodule

// File: rtl/rx_barrel_shift.sv
module rx_barrel_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              go_left,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stg [0:SH_W];

  assign stg[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [DATA_W-1:0] moved;
    assign moved      = go_left ? (stg[i] << STEP) : (stg[i] >> STEP);
    assign stg[i+1]   = amt[i] ? moved : stg[i];
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/rx_alu_core.sv
module rx_alu_core
  import rx_alu_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int SH_W   = SHAMT_W
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [DATA_W-1:0] b_ext,
  input  logic              imm_sel,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] b_opnd;
  logic [DATA_W-1:0] shifted;
  logic              lt_s;
  logic              lt_u;
  logic              shift_left;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_sub(input logic [DATA_W-1:0] x,
                                              input logic [DATA_W-1:0] y);
    return x + ~y + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] f_flag(input logic f);
    return {{(DATA_W-1){1'b0}}, f};
  endfunction

  assign b_opnd     = imm_sel ? b_ext : b_reg;
  assign shift_left = (op == OP_SLL);

  rx_cmp_unit #(.DATA_W(DATA_W)) cmp_i (
    .a          (a),
    .b          (b_opnd),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  rx_barrel_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) shf_i (
    .din    (a),
    .amt    (shamt),
    .go_left(shift_left),
    .dout   (shifted)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDI:    result = f_add(a, b_opnd);
      OP_SUB:             result = f_sub(a, b_opnd);
      OP_AND, OP_ANDI:    result = a & b_opnd;
      OP_OR, OP_ORI:      result = a | b_opnd;
      OP_NOR:             result = ~(a | b_opnd);
      OP_SLT, OP_SLTI:    result = f_flag(lt_s);
      OP_SLTU, OP_SLTIU:  result = f_flag(lt_u);
      OP_SLL, OP_SRL:     result = shifted;
      OP_LUI:             result = b_opnd;
      default:            result = '0;
    endcase
  end
endmodule

// File: rtl/rx_int_alu.sv
module rx_int_alu
  import rx_alu_pkg::*;
#(
  parameter int DATA_W  = XLEN,
  parameter int IMM_LEN = IMM_W,
  parameter int SH_W    = SHAMT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_LEN-1:0] imm_in,
  input  logic [SH_W-1:0]   shamt_in,
  output logic [DATA_W-1:0] res_q,
  output logic              zero_q
);
  localparam int PAD = DATA_W - IMM_LEN;

  alu_op_e           op_e;
  logic [DATA_W-1:0] ext_val;
  logic              imm_sel;
  logic [DATA_W-1:0] result_c;
  logic              zero_c;

  assign op_e = alu_op_e'(op_sel);

  rx_imm_ext #(.DATA_W(DATA_W), .IMM_LEN(IMM_LEN)) ext_i (
    .imm    (imm_in),
    .op     (op_e),
    .ext_val(ext_val),
    .imm_sel(imm_sel)
  );

  rx_alu_core #(.DATA_W(DATA_W), .SH_W(SH_W)) core_i (
    .op     (op_e),
    .a      (opnd_a),
    .b_reg  (opnd_b),
    .b_ext  (ext_val),
    .imm_sel(imm_sel),
    .shamt  (shamt_in),
    .result (result_c)
  );

  assign zero_c = ~|result_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      res_q  <= result_c;
      zero_q <= zero_c;
    end
  end

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q == (res_q == '0));

  // R8
  upper_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_LUI) |=> (res_q[PAD-1:0] == '0) && (res_q[DATA_W-1:PAD] == $past(imm_in)));

  // R4
  nor_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_NOR && opnd_b == '0) |=> (res_q == ~$past(opnd_a)));

  // R5
  slt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SLT && opnd_a[DATA_W-1] && !opnd_b[DATA_W-1]) |=> (res_q == {{(DATA_W-1){1'b0}}, 1'b1}));

  // R6
  sltu_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SLTU && opnd_a == opnd_b) |=> (res_q == '0));

  // R7
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SLL && shamt_in == '0) |=> (res_q == $past(opnd_a)));

  // R10
  rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RSVD) |=> (res_q == '0) && zero_q);
endmodule

// File: tb/rx_int_alu_tb.sv
`timescale 1ns/100ps
module rx_int_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm_in = '0;
  logic [4:0]  shamt_in = '0;
  logic [31:0] res_q;
  logic        zero_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rx_int_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .imm_in(imm_in), .shamt_in(shamt_in),
    .res_q(res_q), .zero_q(zero_q)
  );

  localparam longint M32 = 64'h1_0000_0000;

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input int sh);
    longint ua, ub, sa, sb, simm, ui, v;
    ua = longint'(a);
    ub = longint'(b);
    sa = (ua >= 64'h8000_0000) ? ua - M32 : ua;
    sb = (ub >= 64'h8000_0000) ? ub - M32 : ub;
    ui = longint'(imm);
    simm = (ui >= 32768) ? ui - 65536 : ui;
    case (op)
      0:  v = (ua + ub) % M32;
      1:  v = (ua - ub + M32) % M32;
      2:  v = longint'(a & b);
      3:  v = longint'(a | b);
      4:  v = (M32 - 1) - longint'(a | b);
      5:  v = (sa < sb) ? 1 : 0;
      6:  v = (ua < ub) ? 1 : 0;
      7:  v = (ua * (longint'(1) << sh)) % M32;
      8:  v = ua / (longint'(1) << sh);
      9:  v = ui * 65536;
      10: v = (ua + simm + M32) % M32;
      11: v = ua & ui;
      12: v = ua | ui;
      13: v = (sa < simm) ? 1 : 0;
      14: v = (ua < ((simm + M32) % M32)) ? 1 : 0;
      default: v = 0;
    endcase
    return v[31:0];
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1:   return "R1";
      10:     return "R2";
      11, 12: return "R3";
      2, 3, 4: return "R4";
      5, 13:  return "R5";
      6, 14:  return "R6";
      7, 8:   return "R7";
      9:      return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input int sh, input string tag);
    logic [31:0] exp;
    op_sel   = op[3:0];
    opnd_a   = a;
    opnd_b   = b;
    imm_in   = imm;
    shamt_in = sh[4:0];
    exp = model(op, a, b, imm, sh);
    @(posedge clk);
    #1;
    check32(tag, res_q, exp);
    check32("R9", {31'd0, zero_q}, {31'd0, exp == 32'd0});
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check32("R10", res_q, 32'd0);
    check32("R9", {31'd0, zero_q}, 32'd1);
    rst_n = 1'b1;

    apply(0, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, "R1");
    apply(1, 32'd5, 32'd7, 16'h0, 0, "R1");
    apply(1, 32'h8000_0000, 32'd1, 16'h0, 0, "R1");
    apply(10, 32'd10, 32'd0, 16'hFFFF, 0, "R2");
    apply(10, 32'd0, 32'd0, 16'h8000, 0, "R2");
    apply(10, 32'd1, 32'd0, 16'hFFFF, 0, "R2");
    apply(10, 32'd100, 32'd0, 16'h7FFF, 0, "R2");
    apply(11, 32'hFFFF_FFFF, 32'd0, 16'h8001, 0, "R3");
    apply(12, 32'h1234_0000, 32'd0, 16'hF00F, 0, "R3");
    apply(2, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 0, "R4");
    apply(3, 32'hF0F0_0000, 32'h0000_0F0F, 16'h0, 0, "R4");
    apply(4, 32'h1234_5678, 32'd0, 16'h0, 0, "R4");
    apply(4, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 0, "R4");
    apply(5, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, "R5");
    apply(5, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 0, "R5");
    apply(5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, "R5");
    apply(13, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 0, "R5");
    apply(6, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, "R6");
    apply(6, 32'd1, 32'hFFFF_FFFF, 16'h0, 0, "R6");
    apply(14, 32'h0001_0000, 32'd0, 16'h8000, 0, "R6");
    apply(7, 32'd9, 32'd0, 16'h0, 4, "R7");
    apply(7, 32'h0000_0003, 32'd0, 16'h0, 31, "R7");
    apply(8, 32'h8000_0000, 32'd0, 16'h0, 31, "R7");
    apply(8, 32'hDEAD_BEEF, 32'd0, 16'h0, 0, "R7");
    apply(9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h003D, 0, "R8");
    apply(9, 32'd0, 32'd0, 16'h0000, 0, "R8");
    apply(15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 7, "R10");

    for (int i = 0; i < 600; i++) begin
      int op;
      int sh;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      op  = int'($urandom_range(0, 15));
      sh  = int'($urandom_range(0, 31));
      a   = $urandom();
      b   = (i % 7 == 0) ? a : $urandom();
      imm = 16'($urandom());
      apply(op, a, b, imm, sh, tag_of(op));
    end

    done = 1'b1;
    report();
  end
endmodule